// File: doc/BRIEF.md
# Maskable Fault Latch Interrupt Controller

This block collects eight raw fault signals, arranged as two groups of four, and records each one in a sticky latch. A single active-high interrupt line is raised while any latched fault is enabled by its mask bit. The host services the interrupt over a serial command link. A separate decoder shifts the frames and hands this block the chip-select level, a frame-valid flag, one-hot write strobes for the two mask groups and the two clear groups, and a four-bit data nibble.

When chip select falls, the block copies the latch contents into a status snapshot. The status word returned during the frame reflects that snapshot. Mask writes and latch clears take effect only in the cycle where chip select is first seen high again, and only if the frame was valid. A clear is withheld for any fault that toggled while chip select was low. This ensures that a fault the host has not yet seen is never discarded. A fault that is still present re-arms its latch at once.

Top module: `fault_irq_ctrl`

## Requirements
- R1: Each raw fault passes through a two-flop synchronizer. Once its synchronized level is high, the matching latch sets and stays set after the fault goes away.
- R2: `irq` is high whenever any latched fault has its mask bit set. It is a level signal and stays high without a gap when one of several pending enabled faults is cleared.
- R3: A valid frame with `mask_wr[g]` set loads `cmd_data[k]` into the mask for fault bit 4*g+k, where a 1 enables the interrupt. The other group's mask is unchanged. A latched fault whose mask bit is 0 does not raise `irq`.
- R4: A valid frame with `clr_wr[g]` set clears the latch of fault bit 4*g+k wherever `cmd_data[k]` is 1. Group 0 covers bits 3:0 and group 1 covers bits 7:4.
- R5: Strobes are sampled only in the first cycle in which `cs_n` is seen high after being low. When `frame_ok` is 0 in that cycle, neither masks nor latches change.
- R6: If a fault's synchronized level changes at any point between the falling and rising edges of `cs_n`, a clear for that fault at the end of the frame is skipped.
- R7: If a fault is still present when its clear is applied, the latch remains set and `irq` stays high.
- R8: `status` holds the latch contents captured when `cs_n` falls and does not change until the next fall. A frame with no strobes changes no latch or mask bit.
- R9: After reset, all latches and masks are 0, and `irq` and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_raw | input | 8 | Asynchronous fault conditions, bit 4*g+k belongs to group g |
| cs_n | input | 1 | Chip select from the serial decoder, active low, already in the clock domain |
| frame_ok | input | 1 | Frame had no framing error, sampled at the chip-select rise |
| mask_wr | input | 2 | One-hot mask-write strobe per group, sampled at the chip-select rise |
| clr_wr | input | 2 | One-hot clear strobe per group, sampled at the chip-select rise |
| cmd_data | input | 4 | Data nibble of the command |
| irq | output | 1 | Registered active-high interrupt level |
| status | output | 8 | Latch snapshot taken at the chip-select fall |

## Verification
The main function is tested with five kinds of fault pattern:
- A brief pulse, which shows that the latch is sticky and that the mask gates the interrupt.
- A fault held high through a clear, which shows that the latch re-arms.
- A pulse placed inside the frame that carries the clear, which shows that a clear of a changed fault is skipped.
- Two enabled faults in different groups, where one is cleared while the interrupt line is watched cycle by cycle. This separates level behaviour from pulsed behaviour and checks the group-to-bit mapping.
- A fault latched under a zero mask, which confirms that a disabled flag is still reported in the status snapshot.

Invalid frames and frames with no strobes are placed between these patterns. Each is followed by a status read, so that any unwanted change to a latch or mask shows up at the ports.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  // Chip-select events seen by the latch bank
  typedef struct packed {
    logic fall;    // first low cycle of a frame
    logic rise;    // first high cycle after a frame
    logic active;  // frame in progress (registered chip select low)
  } cs_evt_t;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fault_frame_tracker.sv
module fault_frame_tracker
  import fault_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic [W-1:0] fault_s,
  input  logic [W-1:0] lat_q,
  output cs_evt_t      evt,
  output logic [W-1:0] hold,
  output logic [W-1:0] snap_q
);
  logic         cs_q;
  logic [W-1:0] fs_d;
  logic [W-1:0] chg_q;
  logic [W-1:0] edge_now;

  assign evt.fall   = cs_q & ~cs_n;
  assign evt.rise   = ~cs_q & cs_n;
  assign evt.active = ~cs_q;
  assign edge_now   = fault_s ^ fs_d;
  // Changes seen earlier in the frame, plus one arriving in the rise cycle
  assign hold       = chg_q | (edge_now & {W{~cs_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      fs_d   <= '0;
      chg_q  <= '0;
      snap_q <= '0;
    end else begin
      cs_q <= cs_n;
      fs_d <= fault_s;
      if (evt.fall)        chg_q <= '0;
      else if (evt.active) chg_q <= chg_q | edge_now;
      if (evt.fall)        snap_q <= lat_q;
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !evt.fall |=> $stable(snap_q)) else $error("snapshot moved outside a frame start"); // R8
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank #(
  parameter int GROUPS  = 2,
  parameter int GROUP_W = 4,
  localparam int N      = GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       fault_s,
  input  logic               rise,
  input  logic               frame_ok,
  input  logic [GROUPS-1:0]  mask_wr,
  input  logic [GROUPS-1:0]  clr_wr,
  input  logic [GROUP_W-1:0] cmd_data,
  input  logic [N-1:0]       hold,
  output logic [N-1:0]       lat_q,
  output logic [N-1:0]       mask_q
);
  logic apply;
  assign apply = rise & frame_ok;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] clr_g;
    assign clr_g = (apply && clr_wr[g]) ? (cmd_data & ~hold[g*GROUP_W +: GROUP_W]) : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g*GROUP_W +: GROUP_W] <= '0;
        lat_q[g*GROUP_W +: GROUP_W]  <= '0;
      end else begin
        if (apply && mask_wr[g]) mask_q[g*GROUP_W +: GROUP_W] <= cmd_data;
        // A present fault wins over its own clear
        lat_q[g*GROUP_W +: GROUP_W] <= (lat_q[g*GROUP_W +: GROUP_W] & ~clr_g)
                                      | fault_s[g*GROUP_W +: GROUP_W];
      end
    end
  end

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(rise && frame_ok && (|clr_wr)) |=> ((lat_q & $past(lat_q)) == $past(lat_q)))
    else $error("latch fell without a clear"); // R1
  AST_BAD_FRAME_NOP: assert property (@(posedge clk) disable iff (rst)
    (rise && !frame_ok) |=> ($stable(mask_q) && ((lat_q & $past(lat_q)) == $past(lat_q))))
    else $error("invalid frame changed state"); // R5
  AST_CHANGED_KEPT: assert property (@(posedge clk) disable iff (rst)
    rise |=> ((lat_q & $past(hold & lat_q)) == $past(hold & lat_q)))
    else $error("changed fault was cleared"); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(rise && frame_ok && (|mask_wr)) |=> $stable(mask_q))
    else $error("mask moved without a write"); // R8
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int GROUPS      = 2,
  parameter int GROUP_W     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int N          = GROUPS * GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       fault_raw,
  input  logic               cs_n,
  input  logic               frame_ok,
  input  logic [GROUPS-1:0]  mask_wr,
  input  logic [GROUPS-1:0]  clr_wr,
  input  logic [GROUP_W-1:0] cmd_data,
  output logic               irq,
  output logic [N-1:0]       status
);
  logic [N-1:0] fault_s;
  logic [N-1:0] lat_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] hold;
  cs_evt_t      evt;
  logic         irq_q;

  fault_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(fault_raw), .q(fault_s)
  );

  fault_frame_tracker #(.W(N)) u_trk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fault_s(fault_s), .lat_q(lat_q),
    .evt(evt), .hold(hold), .snap_q(status)
  );

  fault_latch_bank #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_bank (
    .clk(clk), .rst(rst), .fault_s(fault_s), .rise(evt.rise),
    .frame_ok(frame_ok), .mask_wr(mask_wr), .clr_wr(clr_wr),
    .cmd_data(cmd_data), .hold(hold), .lat_q(lat_q), .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(lat_q & mask_q);
  end
  assign irq = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ((|(lat_q & mask_q)) && $stable(lat_q) && $stable(mask_q)) |-> irq_q)
    else $error("enabled latch without interrupt"); // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (|($past(lat_q) & $past(mask_q))))
    else $error("interrupt without enabled latch"); // R2
endmodule

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] fault_raw = '0;
  logic         cs_n = 1'b1;
  logic         frame_ok = 1'b0;
  logic [1:0]   mask_wr = '0;
  logic [1:0]   clr_wr = '0;
  logic [3:0]   cmd_data = '0;
  logic         irq;
  logic [N-1:0] status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [N:0] exp_q [$];
  string      tag_q [$];
  event       chk_ev;
  logic       watch = 1'b0;
  logic       dropped = 1'b0;

  always #10 clk = ~clk;

  fault_irq_ctrl u_fault_irq_ctrl (
    .clk(clk), .rst(rst), .fault_raw(fault_raw), .cs_n(cs_n),
    .frame_ok(frame_ok), .mask_wr(mask_wr), .clr_wr(clr_wr),
    .cmd_data(cmd_data), .irq(irq), .status(status)
  );

  // Monitor: pops expected items and compares at the next falling edge
  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [N:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if ({irq, status} !== e) begin
          n_bad++;
          $display("FAIL %s: irq/status got %b/%h expected %b/%h", t, irq, status, e[N], e[N-1:0]);
        end
      end
    end
  end

  always @(negedge clk) if (watch && !irq) dropped = 1'b1;

  task automatic expect_out(input string t, input logic ei, input logic [N-1:0] es);
    exp_q.push_back({ei, es});
    tag_q.push_back(t);
    -> chk_ev;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int b, input int len);
    @(negedge clk); fault_raw[b] = 1'b1;
    repeat (len) @(negedge clk);
    fault_raw[b] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // One serial frame; strobes ride on the first high cycle of cs_n
  task automatic frame(input logic ok, input logic [1:0] mw, input logic [1:0] cw,
                       input logic [3:0] d, input int pbit);
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    if (pbit >= 0) begin
      fault_raw[pbit] = 1'b1;
      repeat (2) @(negedge clk);
      fault_raw[pbit] = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1; frame_ok = ok; mask_wr = mw; clr_wr = cw; cmd_data = d;
    @(negedge clk);
    frame_ok = 1'b0; mask_wr = '0; clr_wr = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic null_frame();
    frame(1'b1, 2'b00, 2'b00, 4'h0, -1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R9 reset state", 1'b0, 8'h00);

    pulse(0, 3);
    null_frame();
    expect_out("R1 sticky latch, R9 mask zero after reset", 1'b0, 8'h01);

    frame(1'b1, 2'b01, 2'b00, 4'b0001, -1);
    expect_out("R3 mask0 enables bit0", 1'b1, 8'h01);
    frame(1'b1, 2'b10, 2'b00, 4'b0000, -1);
    expect_out("R3 mask1 write leaves group0", 1'b1, 8'h01);

    frame(1'b0, 2'b00, 2'b01, 4'b0001, -1);
    expect_out("R5 clear on bad frame ignored", 1'b1, 8'h01);
    frame(1'b0, 2'b01, 2'b00, 4'b0000, -1);
    expect_out("R5 mask write on bad frame ignored", 1'b1, 8'h01);
    null_frame();
    expect_out("R8 null frame keeps state", 1'b1, 8'h01);

    frame(1'b1, 2'b00, 2'b01, 4'b0001, -1);
    expect_out("R4 clear0 drops irq, snapshot from frame start", 1'b0, 8'h01);
    null_frame();
    expect_out("R4 latch cleared", 1'b0, 8'h00);

    @(negedge clk); fault_raw[2] = 1'b1;
    repeat (6) @(negedge clk);
    frame(1'b1, 2'b01, 2'b00, 4'b0101, -1);
    expect_out("R2 held fault raises irq", 1'b1, 8'h04);
    frame(1'b1, 2'b00, 2'b01, 4'b0100, -1);
    null_frame();
    expect_out("R7 present fault re-latches", 1'b1, 8'h04);
    fault_raw[2] = 1'b0;
    repeat (6) @(negedge clk);
    frame(1'b1, 2'b00, 2'b01, 4'b0100, -1);
    null_frame();
    expect_out("R7 clear after fault gone", 1'b0, 8'h00);

    pulse(0, 3);
    frame(1'b1, 2'b00, 2'b01, 4'b0001, 0);
    expect_out("R6 changed fault not cleared", 1'b1, 8'h01);
    null_frame();
    expect_out("R6 latch still set", 1'b1, 8'h01);
    frame(1'b1, 2'b00, 2'b01, 4'b0001, -1);
    null_frame();
    expect_out("R6 quiet frame clears", 1'b0, 8'h00);

    frame(1'b1, 2'b10, 2'b00, 4'b0010, -1);
    @(negedge clk); fault_raw[0] = 1'b1; fault_raw[5] = 1'b1;
    repeat (3) @(negedge clk);
    fault_raw[0] = 1'b0; fault_raw[5] = 1'b0;
    repeat (6) @(negedge clk);
    expect_out("R2 two enabled faults", 1'b1, 8'h00);
    watch = 1'b1;
    frame(1'b1, 2'b00, 2'b10, 4'b0010, -1);
    watch = 1'b0;
    n_cmp++;
    if (dropped) begin
      n_bad++;
      $display("FAIL R2 level: irq dropped got 0 expected 1");
    end
    null_frame();
    expect_out("R4 clear1 removes bit5 only", 1'b1, 8'h01);
    frame(1'b1, 2'b00, 2'b01, 4'b0001, -1);
    null_frame();
    expect_out("R2 last clear drops irq", 1'b0, 8'h00);

    pulse(7, 3);
    null_frame();
    expect_out("R3 masked fault reported without irq", 1'b0, 8'h80);
    frame(1'b1, 2'b00, 2'b10, 4'b1000, -1);
    null_frame();
    expect_out("R4 clear1 bit7", 1'b0, 8'h00);

    summary();
  end
endmodule